// File: doc/BRIEF.md
# Numeric Picture-String Formatter

This block turns a decimal operand into a printable character field under the control of an edit picture. The operand arrives as a buffer of BCD digits plus the count of digits that lie to the right of its decimal point. It is latched on a start pulse. The picture follows as a byte stream, one character per cycle, and the block stores it in a small entry buffer. While it stores the picture it expands repeat prefixes, gathers quoted literals and counts how many integer digit positions the picture holds. This count lets the operand be aligned on its decimal point before the first output character.

Output is produced in one pass from the most significant position to the least significant. The block emits at most one character per cycle on a valid-qualified byte output. It keeps significance, fill and floating-currency state as it goes, so that it can apply zero suppression, check protection, conditional separators and a floating dollar sign. A one-cycle done pulse closes the field. An overflow flag is set when the operand has nonzero integer digits that the picture has no room for.

Top module: `numeric_picture_fmt`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, out_valid, done, pic_ready and overflow are all low.
- R2: A start pulse in the idle state latches op_digits and op_frac and raises pic_ready from the next cycle. Each picture byte offered with pic_valid while pic_ready is high is taken. The byte marked pic_last ends the picture. Output begins afterwards, and pic_ready stays low until the next start.
- R3: A `D` position always prints the operand digit aligned to it, leading zeros included. Digit k of op_digits sits at bits 4k+3..4k, and k=0 is the least significant. op_frac (0..NDIG) digits lie right of the point. Positions beyond the operand print 0, and fraction digits beyond the picture are dropped.
- R4: A `Z` position prints its digit when that digit is nonzero or a digit has already been printed. Otherwise it prints a blank (0x20). Printing any digit makes the field significant for every later position.
- R5: A `*` position follows the rule of R4 but prints `*` in place of the blank, and from then on the fill character is `*`.
- R6: A `C` position prints `,` once the field is significant, and otherwise prints the current fill character (blank until a `*` position has been seen).
- R7: A `$` picture character prints nothing itself. It arms a floating currency sign, and one `$` is printed immediately before the first digit printed after it.
- R8: A run of decimal numerals n (n≥1) in front of a picture character repeats that character n times. A prefix of 0 counts as 1.
- R9: `.` prints a point and switches alignment to the fraction side, `B` prints a blank, characters between single quotes are copied unchanged, and any other character is copied unchanged.
- R10: overflow, updated in the cycle done is high and held otherwise, is high when any nonzero operand digit lies left of the picture's integer positions.
- R11: Output characters appear only while the picture is not being accepted. done is a single-cycle pulse one cycle after the last output character, and no character is emitted with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch operand and begin picture intake (idle only) |
| op_digits | input | NDIG*4 | BCD operand digits, digit 0 least significant |
| op_frac | input | FRAC_W | Number of operand digits right of the point |
| pic_valid | input | 1 | Picture byte present |
| pic_char | input | 8 | Picture byte (ASCII) |
| pic_last | input | 1 | Marks the final picture byte |
| pic_ready | output | 1 | Picture intake open |
| out_valid | output | 1 | Output character valid this cycle |
| out_char | output | 8 | Output character (ASCII) |
| done | output | 1 | Field complete pulse |
| overflow | output | 1 | Integer digits lost for lack of picture positions |

## Verification
The bench aims at where significance begins. If the floating `$` is placed one position late, it overwrites a digit. If commas do not consult significance, separators show up inside the blank or asterisk lead-in. It runs all-zero operands, which a design that seeds significance from D positions or the point would print as digits instead of blanks. It also runs pictures that are shorter than the operand on both sides of the point, where faulty alignment shifts every digit and a faulty overflow mask either misses the lost digits or flags leading zeros. Repeat prefixes and quoted numerals are mixed into the random pictures, so that a design that treats a quoted digit as a prefix produces a field of the wrong length.

// File: rtl/npf_pkg.sv
package npf_pkg;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOAD = 2'd1,
      S_EMIT = 2'd2
   } npf_state_t;

   localparam logic [7:0] PC_FORCE  = "D";
   localparam logic [7:0] PC_SUPP   = "Z";
   localparam logic [7:0] PC_STAR   = "*";
   localparam logic [7:0] PC_SEP    = "C";
   localparam logic [7:0] PC_POINT  = ".";
   localparam logic [7:0] PC_BLANK  = "B";
   localparam logic [7:0] PC_CURR   = "$";
   localparam logic [7:0] PC_QUOTE  = 8'h27;
   localparam logic [7:0] AS_SPACE  = 8'h20;
   localparam logic [7:0] AS_ZERO   = "0";
   localparam logic [7:0] AS_NINE   = "9";

   function automatic logic is_digit_slot(input logic [7:0] c);
      return (c == PC_FORCE) || (c == PC_SUPP) || (c == PC_STAR);
   endfunction

   function automatic logic is_numeral(input logic [7:0] c);
      return (c >= AS_ZERO) && (c <= AS_NINE);
   endfunction

endpackage

// File: rtl/npf_pic_loader.sv
module npf_pic_loader
   import npf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int REP_W = 4,
   parameter int CNT_W = 8,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [7:0]       ch,
   output logic [7:0]       ent_ch  [DEPTH],
   output logic [REP_W-1:0] ent_rep [DEPTH],
   output logic             ent_lit [DEPTH],
   output logic [IDX_W-1:0] n_ent,
   output logic [CNT_W-1:0] int_cnt
);

   logic             in_quote;
   logic             seen_pt;
   logic [REP_W-1:0] rep_acc;
   logic [REP_W+3:0] rep_next;
   logic [REP_W-1:0] rep_use;
   logic             room;
   logic             wr;
   logic             wr_lit;
   logic [REP_W-1:0] wr_rep;

   always_comb begin
      rep_next = ({4'b0000, rep_acc} * (REP_W+4)'(10)) + (REP_W+4)'(ch[3:0]);
      rep_use  = (rep_acc == '0) ? REP_W'(1) : rep_acc;
      room     = (n_ent < IDX_W'(DEPTH));
      if (in_quote) begin
         wr     = take && room && (ch != PC_QUOTE);
         wr_lit = 1'b1;
         wr_rep = REP_W'(1);
      end else begin
         wr     = take && room && (ch != PC_QUOTE) && !is_numeral(ch);
         wr_lit = 1'b0;
         wr_rep = rep_use;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_ent    <= '0;
         int_cnt  <= '0;
         in_quote <= 1'b0;
         seen_pt  <= 1'b0;
         rep_acc  <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            ent_ch[k]  <= '0;
            ent_rep[k] <= '0;
            ent_lit[k] <= 1'b0;
         end
      end else if (clear) begin
         n_ent    <= '0;
         int_cnt  <= '0;
         in_quote <= 1'b0;
         seen_pt  <= 1'b0;
         rep_acc  <= '0;
      end else if (take) begin
         if (in_quote) begin
            if (ch == PC_QUOTE) in_quote <= 1'b0;
         end else if (ch == PC_QUOTE) begin
            in_quote <= 1'b1;
            rep_acc  <= '0;
         end else if (is_numeral(ch)) begin
            rep_acc <= rep_next[REP_W-1:0];
         end else begin
            rep_acc <= '0;
            if (ch == PC_POINT) seen_pt <= 1'b1;
            if (room && !seen_pt && is_digit_slot(ch))
               int_cnt <= int_cnt + CNT_W'(rep_use);
         end
         if (wr) begin
            n_ent <= n_ent + IDX_W'(1);
            for (int k = 0; k < DEPTH; k++) begin
               if (n_ent == IDX_W'(k)) begin
                  ent_ch[k]  <= ch;
                  ent_rep[k] <= wr_rep;
                  ent_lit[k] <= wr_lit;
               end
            end
         end
      end
   end

endmodule

// File: rtl/npf_digit_select.sv
module npf_digit_select #(
   parameter int NDIG   = 12,
   parameter int FRAC_W = 4,
   parameter int CNT_W  = 8
) (
   input  logic [NDIG*4-1:0] digits,
   input  logic [FRAC_W-1:0] frac,
   input  logic [CNT_W-1:0]  int_idx,
   input  logic [CNT_W-1:0]  fpos,
   input  logic              in_frac,
   input  logic [CNT_W-1:0]  int_cnt,
   output logic [3:0]        digit,
   output logic              ovf
);

   localparam int SUM_W = ((FRAC_W > CNT_W) ? FRAC_W : CNT_W) + 1;

   logic [SUM_W-1:0] sel_idx;
   logic             sel_ok;
   logic [SUM_W-1:0] top_int;
   logic [NDIG-1:0]  hi_nz;

   always_comb begin
      if (in_frac) begin
         sel_ok  = (fpos != '0) && (SUM_W'(fpos) <= SUM_W'(frac));
         sel_idx = SUM_W'(frac) - SUM_W'(fpos);
      end else begin
         sel_ok  = 1'b1;
         sel_idx = SUM_W'(frac) + SUM_W'(int_idx);
      end
      digit = 4'd0;
      for (int k = 0; k < NDIG; k++) begin
         if (sel_ok && (sel_idx == SUM_W'(k))) digit = digits[k*4 +: 4];
      end
   end

   assign top_int = SUM_W'(frac) + SUM_W'(int_cnt);

   for (genvar k = 0; k < NDIG; k++) begin : g_hi
      assign hi_nz[k] = (digits[k*4 +: 4] != 4'd0) && (SUM_W'(k) >= top_int);
   end

   assign ovf = |hi_nz;

endmodule

// File: rtl/npf_edit_engine.sv
module npf_edit_engine
   import npf_pkg::*;
#(
   parameter int         DEPTH  = 16,
   parameter int         REP_W  = 4,
   parameter int         CNT_W  = 8,
   parameter int         IDX_W  = 5,
   parameter logic [7:0] SEP_CH = ",",
   parameter logic [7:0] PNT_CH = ".",
   parameter logic [7:0] CUR_CH = "$",
   parameter logic [7:0] PROT_CH = "*"
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       ent_ch  [DEPTH],
   input  logic [REP_W-1:0] ent_rep [DEPTH],
   input  logic             ent_lit [DEPTH],
   input  logic [IDX_W-1:0] n_ent,
   input  logic [CNT_W-1:0] int_cnt,
   input  logic [3:0]       digit,
   output logic [CNT_W-1:0] int_idx,
   output logic [CNT_W-1:0] fpos,
   output logic             in_frac,
   output logic             out_valid,
   output logic [7:0]       out_char,
   output logic             fin,
   output logic             ending
);

   logic             active;
   logic [IDX_W-1:0] e;
   logic [REP_W-1:0] cnt;
   logic [CNT_W-1:0] ipos;
   logic             sig;
   logic             flt;
   logic             dol;
   logic [7:0]       fill;

   logic [7:0]       cur_ch;
   logic [REP_W-1:0] cur_rep;
   logic             cur_lit;
   logic             have;
   logic             is_pos;
   logic             prints;
   logic             need_dollar;
   logic             last_rep;
   logic             nx_valid;
   logic [7:0]       nx_char;

   always_comb begin
      cur_ch  = '0;
      cur_rep = REP_W'(1);
      cur_lit = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         if (e == IDX_W'(k)) begin
            cur_ch  = ent_ch[k];
            cur_rep = ent_rep[k];
            cur_lit = ent_lit[k];
         end
      end
   end

   assign int_idx     = ipos - CNT_W'(1);
   assign have        = active && (e < n_ent);
   assign ending      = active && !(e < n_ent);
   assign is_pos      = !cur_lit && is_digit_slot(cur_ch);
   assign prints      = (cur_ch == PC_FORCE) || sig || (digit != 4'd0);
   assign need_dollar = have && is_pos && prints && flt && !dol;
   assign last_rep    = (REP_W'(cnt + REP_W'(1)) == cur_rep) || (cur_rep == '0);

   always_comb begin
      nx_valid = have;
      nx_char  = cur_ch;
      if (have && !cur_lit) begin
         if (is_pos) begin
            if (need_dollar)               nx_char = CUR_CH;
            else if (prints)               nx_char = AS_ZERO + {4'b0000, digit};
            else if (cur_ch == PC_STAR)    nx_char = PROT_CH;
            else                           nx_char = AS_SPACE;
         end else begin
            case (cur_ch)
               PC_SEP:   nx_char = sig ? SEP_CH : fill;
               PC_POINT: nx_char = PNT_CH;
               PC_BLANK: nx_char = AS_SPACE;
               PC_CURR:  nx_valid = 1'b0;
               default:  nx_char = cur_ch;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         e         <= '0;
         cnt       <= '0;
         ipos      <= '0;
         fpos      <= '0;
         in_frac   <= 1'b0;
         sig       <= 1'b0;
         flt       <= 1'b0;
         dol       <= 1'b0;
         fill      <= AS_SPACE;
         out_valid <= 1'b0;
         out_char  <= '0;
         fin       <= 1'b0;
      end else begin
         fin       <= 1'b0;
         out_valid <= nx_valid;
         out_char  <= nx_char;
         if (go) begin
            active  <= 1'b1;
            e       <= '0;
            cnt     <= '0;
            ipos    <= int_cnt;
            fpos    <= CNT_W'(1);
            in_frac <= 1'b0;
            sig     <= 1'b0;
            flt     <= 1'b0;
            dol     <= 1'b0;
            fill    <= AS_SPACE;
         end else if (active) begin
            if (ending) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end else if (need_dollar) begin
               dol <= 1'b1;
            end else begin
               if (last_rep) begin
                  e   <= e + IDX_W'(1);
                  cnt <= '0;
               end else begin
                  cnt <= cnt + REP_W'(1);
               end
               if (!cur_lit) begin
                  if (is_pos) begin
                     if (prints) sig <= 1'b1;
                     if (cur_ch == PC_STAR) fill <= PROT_CH;
                     if (in_frac) fpos <= fpos + CNT_W'(1);
                     else         ipos <= ipos - CNT_W'(1);
                  end
                  if (cur_ch == PC_POINT) in_frac <= 1'b1;
                  if (cur_ch == PC_CURR)  flt     <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/numeric_picture_fmt.sv
module numeric_picture_fmt
   import npf_pkg::*;
#(
   parameter int         NDIG      = 12,
   parameter int         PIC_DEPTH = 16,
   parameter int         REP_W     = 4,
   parameter logic [7:0] SEP_CH    = ",",
   parameter logic [7:0] PNT_CH    = ".",
   parameter logic [7:0] CUR_CH    = "$",
   parameter logic [7:0] PROT_CH   = "*",
   localparam int        FRAC_W    = $clog2(NDIG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NDIG*4-1:0] op_digits,
   input  logic [FRAC_W-1:0] op_frac,
   input  logic              pic_valid,
   input  logic [7:0]        pic_char,
   input  logic              pic_last,
   output logic              pic_ready,
   output logic              out_valid,
   output logic [7:0]        out_char,
   output logic              done,
   output logic              overflow
);

   localparam int REP_MAX = (1 << REP_W) - 1;
   localparam int CNT_W   = $clog2(PIC_DEPTH * REP_MAX + 1);
   localparam int IDX_W   = $clog2(PIC_DEPTH + 1);

   if (NDIG < 1 || PIC_DEPTH < 1 || REP_W < 1 || REP_W > 8) begin : g_bad_param
      $error("numeric_picture_fmt: parameter out of range");
   end

   npf_state_t        state;
   logic [NDIG*4-1:0] op_q;
   logic [FRAC_W-1:0] frac_q;
   logic              go;
   logic              take;
   logic              accept;

   logic [7:0]        ent_ch  [PIC_DEPTH];
   logic [REP_W-1:0]  ent_rep [PIC_DEPTH];
   logic              ent_lit [PIC_DEPTH];
   logic [IDX_W-1:0]  n_ent;
   logic [CNT_W-1:0]  int_cnt;
   logic [CNT_W-1:0]  int_idx;
   logic [CNT_W-1:0]  fpos;
   logic              in_frac;
   logic [3:0]        digit;
   logic              ovf;
   logic              fin;
   logic              ending;

   assign pic_ready = (state == S_LOAD);
   assign take      = pic_valid && pic_ready;
   assign accept    = start && (state == S_IDLE);
   assign done      = fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= '0;
         frac_q   <= '0;
         go       <= 1'b0;
         overflow <= 1'b0;
      end else begin
         go <= take && pic_last;
         if (ending) overflow <= ovf;
         case (state)
            S_IDLE: if (accept) begin
               op_q   <= op_digits;
               frac_q <= op_frac;
               state  <= S_LOAD;
            end
            S_LOAD: if (take && pic_last) state <= S_EMIT;
            S_EMIT: if (fin) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   npf_pic_loader #(
      .DEPTH (PIC_DEPTH),
      .REP_W (REP_W),
      .CNT_W (CNT_W),
      .IDX_W (IDX_W)
   ) u_loader (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .take    (take),
      .ch      (pic_char),
      .ent_ch  (ent_ch),
      .ent_rep (ent_rep),
      .ent_lit (ent_lit),
      .n_ent   (n_ent),
      .int_cnt (int_cnt)
   );

   npf_digit_select #(
      .NDIG   (NDIG),
      .FRAC_W (FRAC_W),
      .CNT_W  (CNT_W)
   ) u_select (
      .digits  (op_q),
      .frac    (frac_q),
      .int_idx (int_idx),
      .fpos    (fpos),
      .in_frac (in_frac),
      .int_cnt (int_cnt),
      .digit   (digit),
      .ovf     (ovf)
   );

   npf_edit_engine #(
      .DEPTH   (PIC_DEPTH),
      .REP_W   (REP_W),
      .CNT_W   (CNT_W),
      .IDX_W   (IDX_W),
      .SEP_CH  (SEP_CH),
      .PNT_CH  (PNT_CH),
      .CUR_CH  (CUR_CH),
      .PROT_CH (PROT_CH)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .ent_ch    (ent_ch),
      .ent_rep   (ent_rep),
      .ent_lit   (ent_lit),
      .n_ent     (n_ent),
      .int_cnt   (int_cnt),
      .digit     (digit),
      .int_idx   (int_idx),
      .fpos      (fpos),
      .in_frac   (in_frac),
      .out_valid (out_valid),
      .out_char  (out_char),
      .fin       (fin),
      .ending    (ending)
   );

endmodule

// File: rtl/numeric_picture_fmt_chk.sv
module numeric_picture_fmt_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic pic_ready,
   input logic out_valid,
   input logic done,
   input logic overflow
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !done && !pic_ready && !overflow));

   p_ready_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pic_ready) |-> $past(start));

   p_ovf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(overflow));

   p_no_out_in_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pic_ready |-> !out_valid);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!out_valid && !pic_ready));

endmodule

bind numeric_picture_fmt numeric_picture_fmt_chk u_chk (.*);

// File: tb/numeric_picture_fmt_test.sv
module numeric_picture_fmt_test;

   localparam int NDIG   = 12;
   localparam int FRAC_W = $clog2(NDIG + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NDIG*4-1:0] op_digits = '0;
   logic [FRAC_W-1:0] op_frac = '0;
   logic              pic_valid = 1'b0;
   logic [7:0]        pic_char = '0;
   logic              pic_last = 1'b0;
   logic              pic_ready;
   logic              out_valid;
   logic [7:0]        out_char;
   logic              done;
   logic              overflow;

   int n_checks = 0;
   int n_fail   = 0;
   int opd [NDIG];
   int frac;
   byte exp_q [$];
   bit  exp_ovf;

   always #5 clk = ~clk;

   numeric_picture_fmt #(.NDIG(NDIG)) uut (.*);

   task automatic check(input bit ok, input string req, input string act, input string expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=\"%s\" expected=\"%s\"", req, act, expv);
      end
   endtask

   task automatic set_op(input string s);
      int nf = 0;
      bit after = 0;
      int pos = 0;
      for (int k = 0; k < NDIG; k++) opd[k] = 0;
      for (int i = 0; i < s.len(); i++) begin
         if (s[i] == ".") after = 1;
         else if (after) nf++;
      end
      for (int i = s.len() - 1; i >= 0; i--) begin
         if (s[i] != "." && pos < NDIG) begin
            opd[pos] = s[i] - "0";
            pos++;
         end
      end
      frac = nf;
   endtask

   function automatic int get_digit(bit infr, int ip, int fp);
      int idx;
      if (infr) begin
         if (fp > frac) return 0;
         return opd[frac - fp];
      end
      idx = frac + ip - 1;
      if (idx < NDIG) return opd[idx];
      return 0;
   endfunction

   function automatic void model(input string pic);
      byte cq [$];
      int  rq [$];
      bit  lq [$];
      bit  inq = 0, seen = 0, infr = 0, sig = 0, flt = 0, dol = 0, pr;
      int  acc = 0, icnt = 0, r, ip, fp = 1, d;
      byte c, fill = " ";
      exp_q.delete();
      for (int i = 0; i < pic.len(); i++) begin
         c = pic[i];
         if (inq) begin
            if (c == 8'h27) inq = 0;
            else begin cq.push_back(c); rq.push_back(1); lq.push_back(1); end
         end else if (c == 8'h27) begin
            inq = 1; acc = 0;
         end else if (c >= "0" && c <= "9") begin
            acc = acc * 10 + (c - "0");
         end else begin
            r = (acc == 0) ? 1 : acc;
            acc = 0;
            cq.push_back(c); rq.push_back(r); lq.push_back(0);
            if (!seen && (c == "D" || c == "Z" || c == "*")) icnt += r;
            if (c == ".") seen = 1;
         end
      end
      ip = icnt;
      for (int j = 0; j < cq.size(); j++) begin
         for (int k = 0; k < rq[j]; k++) begin
            c = cq[j];
            if (lq[j]) exp_q.push_back(c);
            else if (c == "D" || c == "Z" || c == "*") begin
               d  = get_digit(infr, ip, fp);
               pr = (c == "D") || sig || (d != 0);
               if (pr) begin
                  if (flt && !dol) begin exp_q.push_back("$"); dol = 1; end
                  exp_q.push_back(byte'(8'h30 + d));
                  sig = 1;
               end else exp_q.push_back((c == "*") ? byte'("*") : byte'(" "));
               if (c == "*") fill = "*";
               if (infr) fp++; else ip--;
            end else if (c == "C") exp_q.push_back(sig ? byte'(",") : fill);
            else if (c == ".") begin exp_q.push_back("."); infr = 1; end
            else if (c == "B") exp_q.push_back(" ");
            else if (c == "$") flt = 1;
            else exp_q.push_back(c);
         end
      end
      exp_ovf = 0;
      for (int k = 0; k < NDIG; k++)
         if (opd[k] != 0 && k >= frac + icnt) exp_ovf = 1;
   endfunction

   task automatic run_case(input string pic, input bit use_lit, input string lit,
                           input bit lit_ovf, input string tag);
      byte got [$];
      string gs = "", es = "";
      bit fin = 0, got_ovf = 0;
      int guard = 0;
      model(pic);
      if (use_lit) exp_ovf = lit_ovf;
      @(negedge clk);
      for (int k = 0; k < NDIG; k++) op_digits[k*4 +: 4] = 4'(opd[k]);
      op_frac = FRAC_W'(frac);
      start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < pic.len(); i++) begin
         pic_valid = 1;
         pic_char  = pic[i];
         pic_last  = (i == pic.len() - 1);
         @(negedge clk);
      end
      pic_valid = 0;
      pic_last  = 0;
      while (!fin && guard < 400) begin
         @(negedge clk);
         guard++;
         if (out_valid) got.push_back(out_char);
         if (done) begin fin = 1; got_ovf = overflow; end
      end
      foreach (got[i]) gs = {gs, $sformatf("%c", got[i])};
      if (use_lit) es = lit;
      else foreach (exp_q[i]) es = {es, $sformatf("%c", exp_q[i])};
      check(fin, {tag, " R11 done seen"}, fin ? "1" : "0", "1");
      check(gs == es, {tag, " field ", pic}, gs, es);
      check(got_ovf == exp_ovf, {tag, " R10 overflow"}, $sformatf("%0d", got_ovf),
            $sformatf("%0d", exp_ovf));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
      $finish;
   end

   initial begin
      string p;
      int nt, sel;
      bit pt;
      void'($urandom(32'd1971));
      repeat (4) @(negedge clk);
      check(!out_valid && !done && !pic_ready && !overflow, "R1 reset state",
            $sformatf("%0d%0d%0d%0d", out_valid, done, pic_ready, overflow), "0000");
      rst_n = 1;
      @(negedge clk);
      check(!out_valid && !done && !pic_ready && !overflow, "R1 after release",
            $sformatf("%0d%0d%0d%0d", out_valid, done, pic_ready, overflow), "0000");

      set_op("12471.2342");
      run_case("DDDDDDD.DDD", 1, "0012471.234", 0, "R3 R2 forced digits");
      run_case("$ZZZCZZZCZZZ.DD", 1, "     $12,471.23", 0, "R7 R4 R6 floating dollar");
      run_case("'$'B***C***C***.DD", 1, "$ *****12,471.23", 0, "R5 R9 check protect");
      run_case("3Z.2D", 1, "471.23", 1, "R8 R10 repeat and overflow");
      set_op("0000.00");
      run_case("ZZZ.ZZ", 1, "   .  ", 0, "R4 all zero suppressed");
      set_op("5");
      run_case("*C***", 1, "****5", 0, "R6 comma takes fill");
      set_op("7");
      run_case("$DD", 1, "$07", 0, "R7 dollar before forced digit");
      set_op("3.999");
      run_case("D.D", 1, "3.9", 0, "R3 fraction dropped");
      set_op("1234");
      run_case("ZZ-ZZ'x'", 1, "12-34x", 0, "R9 literals");
      set_op("12");
      run_case("'12'DDD", 1, "12012", 0, "R8 quoted numerals are not a prefix");

      for (int t = 0; t < 60; t++) begin
         for (int k = 0; k < NDIG; k++)
            opd[k] = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 9);
         for (int k = $urandom_range(2, NDIG); k < NDIG; k++) opd[k] = 0;
         frac = $urandom_range(0, 5);
         p  = "";
         pt = 0;
         nt = $urandom_range(2, 11);
         for (int i = 0; i < nt; i++) begin
            sel = $urandom_range(0, 11);
            case (sel)
               0, 1, 2, 3: begin
                  if ($urandom_range(0, 3) == 0) p = {p, $sformatf("%0d", $urandom_range(1, 4))};
                  p = {p, (sel == 0) ? "D" : (sel == 3) ? "*" : "Z"};
               end
               4:  p = {p, "C"};
               5:  p = {p, "B"};
               6:  p = {p, "$"};
               7:  if (!pt) begin p = {p, "."}; pt = 1; end else p = {p, "Z"};
               8:  p = {p, "'7'"};
               9:  p = {p, "-"};
               default: p = {p, "Z"};
            endcase
         end
         p = {p, "D"};
         run_case(p, 0, "", 0, "R3 R4 R5 R6 R7 R8 R9 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule